// File: doc/BRIEF.md
# SPI Word Queue Layer with Level-Match Interrupts

This block sits between a register bus and an SPI shift engine and adds a transmit queue and a receive queue, each sixteen 16-bit words deep. Software pushes outgoing words with a write strobe and pops incoming words with a read strobe. The shift engine takes the oldest transmit word whenever it reports idle, and pushes each received word with a valid strobe. Each queue reports its occupancy as a 5-bit value from 0 to 16. Each queue has a run control: while it is low, the queue's pointers and count are held at zero.

Each queue has a programmable trigger level. A sticky match flag sets when the occupancy equals that level exactly, and it is cleared by a write-1 strobe. The flag raises an interrupt only when that queue's interrupt enable is set. The receive side also has a sticky overflow flag, with its own write-1 clear.

A global mode input selects between queued operation and plain single-buffer operation. In plain mode both queues are held empty. Writes then go to a one-word transmit holding register, and reads return the most recently received word.

Top module: `spi_fifo_bridge`

## Requirements
- R1: In queued mode with its run input high, each queue's level output rises by one for each accepted push and falls by one for each pop, over the whole range 0 to 16. A push and a pop in the same cycle leave the level unchanged. A host push into a full transmit queue is discarded.
- R2: Whenever `eng_idle` is high and the transmit queue is not empty, `eng_load` is high in that same cycle and `eng_tx_data` carries the oldest stored word. That word is removed at the next clock edge, so words leave in the order they were written.
- R3: An engine push into a full receive queue discards the new word, keeps the level at 16, and sets `rx_ovf` at that clock edge. The 16 words already stored are read back unchanged.
- R4: A host read of an empty receive queue leaves `rx_level` at 0 and leaves `host_rdata` at its previous value. After a read of a non-empty queue, `host_rdata` shows the popped word from the next cycle onward.
- R5: A match flag sets at the first clock edge at which the queue is running, queued mode is on, and the level equals the trigger level. It then stays set until it is cleared.
- R6: A high clear strobe clears a match flag at the next edge unless the set condition of R5 holds at that same edge; in that case the flag stays set. A low clear strobe changes nothing.
- R7: `tx_irq` is high only while `tx_match` and `tx_irq_en` are both high. `rx_irq` is high only while `rx_match` and `rx_irq_en` are both high.
- R8: While a queue's run input is low, its level reads 0 one cycle later, pushes into it are ignored, `eng_load` stays low for the transmit side, and its match flag does not set.
- R9: With `fifo_en` low, both levels read 0. A host write loads the one-word holding register, which drives `eng_tx_data` and requests `eng_load` while `eng_idle` is high, and empties after one load. A host read returns the latest word pushed by the engine.
- R10: `rx_ovf` stays set until `rx_ovf_clr` is pulsed high. It reads 0 at the edge after that pulse, unless an overflow occurs at the same edge.
- R11: After reset both levels are 0, all flags and interrupts are low, `eng_load` is low and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = queued mode, 0 = plain single-buffer mode |
| tx_run | input | 1 | 0 holds transmit pointers and count at zero |
| rx_run | input | 1 | 0 holds receive pointers and count at zero |
| tx_trig_lvl | input | 5 | Transmit match level |
| rx_trig_lvl | input | 5 | Receive match level |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_match_clr | input | 1 | Write-1 clear of the transmit match flag |
| rx_match_clr | input | 1 | Write-1 clear of the receive match flag |
| rx_ovf_clr | input | 1 | Write-1 clear of the receive overflow flag |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | 16 | Host push word |
| host_rd | input | 1 | Host pop strobe |
| host_rdata | output | 16 | Last word popped by the host (registered) |
| eng_idle | input | 1 | Shift engine can accept a word |
| eng_load | output | 1 | Word handed to the engine this cycle |
| eng_tx_data | output | 16 | Word offered to the engine |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 16 | Received word |
| tx_level | output | 5 | Transmit occupancy 0..16 |
| rx_level | output | 5 | Receive occupancy 0..16 |
| tx_match | output | 1 | Transmit match flag |
| rx_match | output | 1 | Receive match flag |
| rx_ovf | output | 1 | Receive overflow flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench sweeps every trigger level from 0 to 16 on both queues. At each level it steps the occupancy through every value and checks that the flag sets exactly when the level is reached, and not one word early or late. A design that compared with greater-or-equal, or that mis-sized the 5-bit count, would set the flag early or lose the full state. It drives a 17th word into a full receive queue and a read into an empty one: a design that overwrote the oldest word, or that moved a pointer on empty, would return corrupted or shifted data. It also clears a flag while the match still holds, and drops run and mode in the middle of traffic. A design with clear-over-set priority, or with pointers that are not forced, would show a cleared flag or a stale level.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned FIFO_DEPTH = 16;
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic full;
        logic empty;
    } fifo_stat_t;

    typedef enum logic {
        MODE_PLAIN  = 1'b0,
        MODE_QUEUED = 1'b1
    } mode_e;

    // exact-equality trigger, not a threshold
    function automatic logic level_hit(input cnt_t cnt, input cnt_t lvl);
        return cnt == lvl;
    endfunction

endpackage

// File: rtl/sfb_sticky.sv
module sfb_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // set has priority over the write-1 clear
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/sfb_queue.sv
module sfb_queue #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULLC);
    assign do_pop  = run & pop & ~empty;
    assign do_push = run & push & (~full | do_pop);
    assign head    = mem[rp];
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            wp    <= '0;
            rp    <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end
endmodule

// File: rtl/spi_fifo_bridge.sv
module spi_fifo_bridge
    import sfb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_en,
    input  logic        tx_run,
    input  logic        rx_run,
    input  logic [4:0]  tx_trig_lvl,
    input  logic [4:0]  rx_trig_lvl,
    input  logic        tx_irq_en,
    input  logic        rx_irq_en,
    input  logic        tx_match_clr,
    input  logic        rx_match_clr,
    input  logic        rx_ovf_clr,
    input  logic        host_wr,
    input  logic [15:0] host_wdata,
    input  logic        host_rd,
    output logic [15:0] host_rdata,
    input  logic        eng_idle,
    output logic        eng_load,
    output logic [15:0] eng_tx_data,
    input  logic        eng_rx_valid,
    input  logic [15:0] eng_rx_data,
    output logic [4:0]  tx_level,
    output logic [4:0]  rx_level,
    output logic        tx_match,
    output logic        rx_match,
    output logic        rx_ovf,
    output logic        tx_irq,
    output logic        rx_irq
);
    mode_e      mode;
    logic       queued, tx_go, rx_go;
    fifo_stat_t tx_st, rx_st;
    word_t      tx_head, rx_head;
    logic       tx_push, tx_pop, rx_push, rx_pop, rx_drop;

    word_t      tx_hold, rx_hold, rdata_q;
    logic       hold_v;

    assign mode   = fifo_en ? MODE_QUEUED : MODE_PLAIN;
    assign queued = (mode == MODE_QUEUED);
    assign tx_go  = queued & tx_run;
    assign rx_go  = queued & rx_run;

    // transmit side
    assign tx_push = queued & host_wr & ~tx_st.full;
    assign tx_pop  = queued & eng_idle;

    sfb_queue #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_q_i (
        .clk(clk), .rst(rst), .run(tx_go),
        .push(tx_push), .push_data(host_wdata),
        .pop(tx_pop), .head(tx_head),
        .cnt(tx_st.cnt), .full(tx_st.full), .empty(tx_st.empty)
    );

    // receive side
    assign rx_push = queued & eng_rx_valid;
    assign rx_pop  = queued & host_rd;
    assign rx_drop = rx_go & rx_push & rx_st.full & ~(rx_pop & ~rx_st.empty);

    sfb_queue #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_q_i (
        .clk(clk), .rst(rst), .run(rx_go),
        .push(rx_push), .push_data(eng_rx_data),
        .pop(rx_pop), .head(rx_head),
        .cnt(rx_st.cnt), .full(rx_st.full), .empty(rx_st.empty)
    );

    // plain single-buffer path and registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_hold <= '0;
            hold_v  <= 1'b0;
            rx_hold <= '0;
            rdata_q <= '0;
        end else begin
            if (queued) begin
                hold_v <= 1'b0;
            end else if (host_wr) begin
                tx_hold <= host_wdata;
                hold_v  <= 1'b1;
            end else if (eng_idle) begin
                hold_v <= 1'b0;
            end
            if (!queued && eng_rx_valid) rx_hold <= eng_rx_data;
            if (host_rd) begin
                if (!queued)            rdata_q <= rx_hold;
                else if (!rx_st.empty)  rdata_q <= rx_head;
            end
        end
    end

    assign eng_load    = eng_idle & (queued ? ~tx_st.empty : hold_v);
    assign eng_tx_data = queued ? tx_head : tx_hold;
    assign host_rdata  = rdata_q;

    // flags
    sfb_sticky tx_match_i (
        .clk(clk), .rst(rst),
        .set_i(tx_go & level_hit(tx_st.cnt, tx_trig_lvl)),
        .clr_i(tx_match_clr), .q_o(tx_match)
    );
    sfb_sticky rx_match_i (
        .clk(clk), .rst(rst),
        .set_i(rx_go & level_hit(rx_st.cnt, rx_trig_lvl)),
        .clr_i(rx_match_clr), .q_o(rx_match)
    );
    sfb_sticky rx_ovf_i (
        .clk(clk), .rst(rst),
        .set_i(rx_drop), .clr_i(rx_ovf_clr), .q_o(rx_ovf)
    );

    assign tx_level = tx_st.cnt;
    assign rx_level = rx_st.cnt;
    assign tx_irq   = tx_match & tx_irq_en;
    assign rx_irq   = rx_match & rx_irq_en;
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker
    import sfb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        fifo_en,
    input logic        tx_run,
    input logic [4:0]  tx_trig_lvl,
    input logic        tx_irq_en,
    input logic        tx_match_clr,
    input logic        rx_ovf_clr,
    input logic        host_rd,
    input logic [15:0] host_rdata,
    input logic        eng_idle,
    input logic        eng_load,
    input logic [4:0]  tx_level,
    input logic [4:0]  rx_level,
    input logic        tx_match,
    input logic        rx_ovf,
    input logic        tx_irq
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_level <= 5'(FIFO_DEPTH)) && (rx_level <= 5'(FIFO_DEPTH)));

    assert_load_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
        (eng_load && fifo_en) |-> (tx_level != 5'd0));

    assert_load_idle_R2: assert property (@(posedge clk) disable iff (rst)
        eng_load |-> eng_idle);

    assert_ovf_from_full_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovf) |-> ($past(rx_level) == 5'(FIFO_DEPTH)));

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (host_rd && fifo_en && rx_level == 5'd0) |=> $stable(host_rdata));

    assert_match_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_match && !tx_match_clr) |=> tx_match);

    assert_match_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_match_clr && !(fifo_en && tx_run && tx_level == tx_trig_lvl)) |=> !tx_match);

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_irq_en |-> !tx_irq);

    assert_run_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_run |=> (tx_level == 5'd0));

    assert_plain_empty_R9: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (tx_level == 5'd0 && rx_level == 5'd0));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_ovf && !rx_ovf_clr) |=> rx_ovf);
endmodule

bind spi_fifo_bridge sfb_checker chk_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_run(tx_run),
    .tx_trig_lvl(tx_trig_lvl), .tx_irq_en(tx_irq_en),
    .tx_match_clr(tx_match_clr), .rx_ovf_clr(rx_ovf_clr),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_idle(eng_idle), .eng_load(eng_load),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_match(tx_match), .rx_ovf(rx_ovf), .tx_irq(tx_irq)
);

// File: tb/spi_fifo_bridge_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        fifo_en, tx_run, rx_run;
    logic [4:0]  tx_trig_lvl, rx_trig_lvl;
    logic        tx_irq_en, rx_irq_en;
    logic        tx_match_clr, rx_match_clr, rx_ovf_clr;
    logic        host_wr, host_rd, eng_idle, eng_rx_valid;
    logic [15:0] host_wdata, eng_rx_data;
    logic [15:0] host_rdata, eng_tx_data;
    logic        eng_load, tx_match, rx_match, rx_ovf, tx_irq, rx_irq;
    logic [4:0]  tx_level, rx_level;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    spi_fifo_bridge dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .tx_run(tx_run), .rx_run(rx_run),
        .tx_trig_lvl(tx_trig_lvl), .rx_trig_lvl(rx_trig_lvl),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .tx_match_clr(tx_match_clr), .rx_match_clr(rx_match_clr), .rx_ovf_clr(rx_ovf_clr),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .eng_idle(eng_idle), .eng_load(eng_load), .eng_tx_data(eng_tx_data),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_match(tx_match), .rx_match(rx_match),
        .rx_ovf(rx_ovf), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        rst = 1'b1; fifo_en = 0; tx_run = 0; rx_run = 0;
        tx_trig_lvl = 0; rx_trig_lvl = 0; tx_irq_en = 0; rx_irq_en = 0;
        tx_match_clr = 0; rx_match_clr = 0; rx_ovf_clr = 0;
        host_wr = 0; host_rd = 0; eng_idle = 0; eng_rx_valid = 0;
        host_wdata = 0; eng_rx_data = 0;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R11 reset state
        chk("R11 tx_level", tx_level, 0);
        chk("R11 rx_level", rx_level, 0);
        chk("R11 tx_match", tx_match, 0);
        chk("R11 rx_match", rx_match, 0);
        chk("R11 rx_ovf", rx_ovf, 0);
        chk("R11 eng_load", eng_load, 0);
        chk("R11 host_rdata", host_rdata, 0);

        fifo_en = 1;

        // transmit sweep over every trigger level
        for (int lv = 0; lv <= 16; lv++) begin
            tx_run = 0; tx_match_clr = 1;
            tick(); tick();
            tx_match_clr = 0;
            chk("R8 tx_match held low while stopped", tx_match, 0);
            tx_trig_lvl = 5'(lv); tx_irq_en = lv[0]; tx_run = 1;
            tick();
            chk("R5 tx_match at level 0", tx_match, (lv == 0) ? 1 : 0);
            for (int k = 1; k <= 16; k++) begin
                host_wr = 1; host_wdata = 16'(lv * 256 + k);
                tick();
                host_wr = 0;
                chk("R1 tx_level after push", tx_level, k);
                tick();
                chk("R5 tx_match exact level", tx_match, (lv <= k) ? 1 : 0);
                chk("R7 tx_irq gating", tx_irq, ((lv <= k) && lv[0]) ? 1 : 0);
            end
            // extra push into full queue is discarded
            host_wr = 1; host_wdata = 16'hFFFF;
            tick();
            host_wr = 0;
            chk("R1 tx push when full", tx_level, 16);
            eng_idle = 1; #1;
            for (int k = 1; k <= 16; k++) begin
                chk("R2 eng_load while non-empty", eng_load, 1);
                chk("R2 eng_tx_data order", eng_tx_data, lv * 256 + k);
                tick();
                chk("R1 tx_level after pop", tx_level, 16 - k);
            end
            chk("R2 eng_load when empty", eng_load, 0);
            eng_idle = 0;
        end

        // R6 clear while no match, then clear while match holds
        tx_irq_en = 0;
        tx_match_clr = 1;
        tick();
        tx_match_clr = 0;
        chk("R6 clear with no match", tx_match, 0);
        tick();
        chk("R6 no clear strobe keeps state", tx_match, 0);
        tx_trig_lvl = 0;
        tick();
        chk("R5 match on level 0", tx_match, 1);
        tx_match_clr = 1;
        tick();
        tx_match_clr = 0;
        chk("R6 set wins over clear", tx_match, 1);

        // R8 run low drops contents and ignores pushes
        for (int k = 0; k < 3; k++) begin
            host_wr = 1; host_wdata = 16'(k);
            tick();
        end
        host_wr = 0;
        chk("R1 tx_level three words", tx_level, 3);
        tx_run = 0;
        tick();
        chk("R8 tx_level zero when stopped", tx_level, 0);
        host_wr = 1; host_wdata = 16'h0BAD;
        tick();
        host_wr = 0;
        chk("R8 push ignored when stopped", tx_level, 0);
        eng_idle = 1; #1;
        chk("R8 no eng_load when stopped", eng_load, 0);
        eng_idle = 0;
        tx_match_clr = 1;
        tick();
        tx_match_clr = 0;
        tick();
        chk("R8 match cannot set when stopped", tx_match, 0);
        tx_run = 1;

        // receive sweep over every trigger level
        for (int lv = 0; lv <= 16; lv++) begin
            rx_run = 0; rx_match_clr = 1;
            tick(); tick();
            rx_match_clr = 0;
            rx_trig_lvl = 5'(lv); rx_irq_en = ~lv[0]; rx_run = 1;
            tick();
            chk("R5 rx_match at level 0", rx_match, (lv == 0) ? 1 : 0);
            for (int k = 1; k <= 16; k++) begin
                eng_rx_valid = 1; eng_rx_data = 16'(16'hA000 + lv * 256 + k);
                tick();
                eng_rx_valid = 0;
                chk("R1 rx_level after push", rx_level, k);
                tick();
                chk("R5 rx_match exact level", rx_match, (lv <= k) ? 1 : 0);
                chk("R7 rx_irq gating", rx_irq, ((lv <= k) && !lv[0]) ? 1 : 0);
            end
            for (int k = 1; k <= 16; k++) begin
                host_rd = 1;
                tick();
                host_rd = 0;
                chk("R4 host_rdata order", host_rdata, 16'hA000 + lv * 256 + k);
                chk("R1 rx_level after pop", rx_level, 16 - k);
            end
            chk("R3 no overflow in sweep", rx_ovf, 0);
        end

        // R3 overflow: 17th and 18th word dropped
        for (int k = 1; k <= 18; k++) begin
            eng_rx_valid = 1; eng_rx_data = (k <= 16) ? 16'(16'h0100 + k) : 16'hDEAD;
            tick();
            eng_rx_valid = 0;
            chk("R3 rx_ovf timing", rx_ovf, (k >= 17) ? 1 : 0);
        end
        chk("R3 rx_level stays full", rx_level, 16);
        tick();
        chk("R10 rx_ovf sticky", rx_ovf, 1);
        for (int k = 1; k <= 16; k++) begin
            host_rd = 1;
            tick();
            host_rd = 0;
            chk("R3 stored words intact", host_rdata, 16'h0100 + k);
        end
        host_rd = 1;
        tick();
        host_rd = 0;
        chk("R4 empty read keeps data", host_rdata, 16'h0110);
        chk("R4 empty read keeps level", rx_level, 0);
        rx_ovf_clr = 1;
        tick();
        rx_ovf_clr = 0;
        chk("R10 rx_ovf cleared", rx_ovf, 0);

        // R9 plain single-buffer mode
        fifo_en = 0;
        tick();
        chk("R9 tx_level plain", tx_level, 0);
        chk("R9 rx_level plain", rx_level, 0);
        host_wr = 1; host_wdata = 16'h1234;
        tick();
        host_wr = 0;
        chk("R9 write bypasses queue", tx_level, 0);
        chk("R9 no load while busy", eng_load, 0);
        chk("R9 hold data", eng_tx_data, 16'h1234);
        eng_idle = 1; #1;
        chk("R9 load from hold", eng_load, 1);
        tick();
        chk("R9 hold emptied", eng_load, 0);
        eng_idle = 0;
        eng_rx_valid = 1; eng_rx_data = 16'h55AA;
        tick();
        eng_rx_data = 16'h66BB;
        tick();
        eng_rx_valid = 0;
        host_rd = 1;
        tick();
        host_rd = 0;
        chk("R9 read latest word", host_rdata, 16'h66BB);
        chk("R9 rx_level plain after push", rx_level, 0);

        done = 1'b1;
        summary();
    end
endmodule